// File: doc/BRIEF.md
# Circular Averaging Comb Filter

This block averages a stream of signed ADC samples into a circular buffer of N words, so that any signal that repeats every N samples (the buffer's fundamental and all of its harmonics) builds up while uncorrelated noise averages away. Each accepted sample updates one word with a leaky average. A write pointer steps through the buffer and wraps at its end, so the buffer behaves as a comb filter on a grid of the sample rate divided by N. For example, 1000 words at 1 MS/s gives a 1 kHz grid, and 2000 words gives a half-kHz grid.

On a start command a readout engine walks the buffer one word per clock. It multiplies each word by cosine and sine of the harmonic angle and sums the products into wide in-phase and quadrature accumulators. The result is a phase vector at harmonic n of the grid. Samples keep being accumulated while the readout runs. A clear command zeroes the buffer word by word. Reset performs the same clear.

Top module: `comb_avg_filter`

## Requirements
- R1: During and after reset the block zeroes all N words over N cycles with `busy` high, `done` low and `periods` at 0; a readout taken afterwards returns zero on both outputs.
- R2: The k-th sample accepted since the last clear updates word k mod N: the pointer starts at 0, moves up by one per accepted sample and wraps from N-1 to 0.
- R3: An accepted sample s turns word w into w + s - (w >>> K), an arithmetic shift, where K is `avg_shift` limited to at most GUARD; with K = 0 the word becomes s.
- R4: A `start` accepted while idle runs exactly N cycles: `done` is high for one cycle, in the cycle after the start edge plus N clock edges, and `vec_i`/`vec_q` hold the final sums while `done` is high.
- R5: Word i is weighted by the angle 2*pi*p/N with p = (i*n) mod N and n = `harm` (which must be below N). `vec_i` sums word*cosine and `vec_q` sums word*sine, with amplitude 2^(TW-1)-1. At quarter-turn angles the weights are exactly 0 and plus or minus that amplitude.
- R6: A sample that updates the word being read in the same cycle is forwarded, so the readout uses the updated value.
- R7: `start` is ignored while `busy` is high, both during a running readout (it does not restart and `done` appears once) and during a clear.
- R8: `clr` restarts the zeroing pass of N cycles with `busy` high, aborts a running readout without `done`, returns the pointer to word 0 and `periods` to 0, and discards samples that arrive while the pass runs.
- R9: `periods` counts pointer wraps since the last clear and saturates at 2^CNTW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Signed sample |
| avg_shift | input | SKW | Leaky-average shift K |
| clr | input | 1 | Start a zeroing pass |
| start | input | 1 | Start a readout pass |
| harm | input | clog2(N) | Harmonic number n |
| busy | output | 1 | Zeroing or readout in progress |
| done | output | 1 | One-cycle readout completion |
| vec_i | output | ACCW | In-phase sum |
| vec_q | output | ACCW | Quadrature sum |
| periods | output | CNTW | Saturating count of buffer periods |

## Verification
The bench builds the block with N = 8, an eighth-turn step, so harmonics 0, 2, 4 and 6 land only on quarter-turn angles. Every weight is therefore known exactly, and each readout can be predicted to the last bit. A counter width of 3 lets saturation of the period count be reached after seven wraps. With GUARD = 4 and a 3-bit shift field, a shift request of 7 exercises the clamp. The short buffer also makes the zeroing pass, the one-cycle forwarding window and the start/done spacing short enough to check on every cycle of the pass.

// File: rtl/comb_pkg.sv
package comb_pkg;

   typedef enum logic {
      CS_IDLE = 1'b0,
      CS_RUN  = 1'b1
   } corr_state_t;

   // Quarter-wave sine sample j of q steps, rational approximation exact at 0 and q
   function automatic int quarter_sine(input int j, input int q, input int amp);
      longint u;
      longint num;
      longint den;
      u   = longint'(j) * longint'(2 * q - j);
      num = longint'(amp) * 4 * u;
      den = 5 * longint'(q) * longint'(q) - u;
      return int'(num / den);
   endfunction

endpackage

// File: rtl/comb_ring_acc.sv
module comb_ring_acc #(
   parameter int N     = 1000,
   parameter int DW    = 16,
   parameter int GUARD = 4,
   parameter int SKW   = 3,
   parameter int CNTW  = 8,
   localparam int AW   = $clog2(N),
   localparam int BW   = DW + GUARD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] smp_data,
   input  logic [SKW-1:0]       avg_shift,
   input  logic [AW-1:0]        rd_addr,
   output logic signed [BW-1:0] rd_word,
   output logic                 clearing,
   output logic [CNTW-1:0]      periods
);
   localparam logic [AW-1:0]   LAST = AW'(N - 1);
   localparam logic [CNTW-1:0] CMAX = '1;
   localparam logic [SKW-1:0]  KMAX = SKW'(GUARD);

   logic signed [BW-1:0] mem [N];
   logic [AW-1:0]        wptr;
   logic [AW-1:0]        cptr;
   logic                 fire;
   logic [SKW-1:0]       k_eff;
   logic signed [BW-1:0] old_w;
   logic signed [BW-1:0] smp_w;
   logic signed [BW-1:0] upd_w;

   always_comb begin
      fire    = smp_valid && !clearing && !clr;
      k_eff   = (avg_shift > KMAX) ? KMAX : avg_shift;
      old_w   = mem[wptr];
      smp_w   = {{GUARD{smp_data[DW-1]}}, smp_data};
      upd_w   = old_w + smp_w - (old_w >>> k_eff);
      rd_word = (fire && (wptr == rd_addr)) ? upd_w : mem[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (clearing) begin
         mem[cptr] <= '0;
      end else if (fire) begin
         mem[wptr] <= upd_w;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clearing <= 1'b1;
         cptr     <= '0;
         wptr     <= '0;
         periods  <= '0;
      end else if (clr) begin
         clearing <= 1'b1;
         cptr     <= '0;
         wptr     <= '0;
         periods  <= '0;
      end else if (clearing) begin
         if (cptr == LAST) begin
            clearing <= 1'b0;
            cptr     <= '0;
         end else begin
            cptr <= cptr + 1'b1;
         end
      end else if (fire) begin
         if (wptr == LAST) begin
            wptr <= '0;
            if (periods != CMAX) periods <= periods + 1'b1;
         end else begin
            wptr <= wptr + 1'b1;
         end
      end
   end

   p_wptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && wptr != LAST) |=> (wptr == $past(wptr) + 1'b1));
   p_wptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && wptr == LAST) |=> (wptr == '0));
   p_clear_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (clearing && wptr == '0 && periods == '0));
   p_clear_hold_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clearing && !clr) |=> $stable(wptr));
   p_period_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (periods == CMAX && !clr) |=> (periods == CMAX));

endmodule

// File: rtl/comb_trig_lut.sv
module comb_trig_lut
   import comb_pkg::*;
#(
   parameter int QBITS  = 8,
   parameter int TW     = 16,
   localparam int POSW  = QBITS + 2
) (
   input  logic [POSW-1:0]      pos,
   output logic signed [TW-1:0] sin_v,
   output logic signed [TW-1:0] cos_v
);
   localparam int Q   = 1 << QBITS;
   localparam int AMP = (1 << (TW - 1)) - 1;

   logic signed [TW-1:0] tbl [Q+1];

   for (genvar j = 0; j <= Q; j++) begin : g_tbl
      assign tbl[j] = TW'(quarter_sine(j, Q, AMP));
   end

   logic [1:0]           quad;
   logic [QBITS:0]       i_lo;
   logic [QBITS:0]       i_hi;
   logic signed [TW-1:0] lo;
   logic signed [TW-1:0] hi;

   always_comb begin
      quad = pos[POSW-1:POSW-2];
      i_lo = {1'b0, pos[QBITS-1:0]};
      i_hi = (QBITS+1)'(Q) - i_lo;
      lo   = tbl[i_lo];
      hi   = tbl[i_hi];
      unique case (quad)
         2'd0:    begin sin_v = lo;  cos_v = hi;  end
         2'd1:    begin sin_v = hi;  cos_v = -lo; end
         2'd2:    begin sin_v = -lo; cos_v = -hi; end
         default: begin sin_v = -hi; cos_v = lo;  end
      endcase
   end

endmodule

// File: rtl/comb_correlator.sv
module comb_correlator
   import comb_pkg::*;
#(
   parameter int N      = 1000,
   parameter int BW     = 20,
   parameter int TW     = 16,
   parameter int QBITS  = 8,
   parameter int ACCW   = 48,
   localparam int AW    = $clog2(N),
   localparam int POSW  = QBITS + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   hold,
   input  logic [AW-1:0]          harm,
   input  logic signed [BW-1:0]   rd_word,
   input  logic signed [TW-1:0]   sin_v,
   input  logic signed [TW-1:0]   cos_v,
   output logic [AW-1:0]          rd_addr,
   output logic [POSW-1:0]        pos,
   output logic                   running,
   output logic                   done,
   output logic signed [ACCW-1:0] acc_i,
   output logic signed [ACCW-1:0] acc_q
);
   localparam int MW = AW + POSW;
   localparam logic [AW-1:0] LAST  = AW'(N - 1);
   localparam logic [MW-1:0] SCALE = MW'(4 * (1 << QBITS));
   localparam logic [MW-1:0] DIVN  = MW'(N);

   corr_state_t             st;
   logic [AW-1:0]           ph;
   logic [AW:0]             ph_sum;
   logic [AW-1:0]           ph_nxt;
   logic signed [BW+TW-1:0] p_i;
   logic signed [BW+TW-1:0] p_q;

   always_comb begin
      running = (st == CS_RUN);
      ph_sum  = {1'b0, ph} + {1'b0, harm};
      ph_nxt  = (ph_sum >= (AW+1)'(N)) ? AW'(ph_sum - (AW+1)'(N)) : ph_sum[AW-1:0];
      pos     = POSW'(({{POSW{1'b0}}, ph} * SCALE) / DIVN);
      p_i     = rd_word * cos_v;
      p_q     = rd_word * sin_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CS_IDLE;
         rd_addr <= '0;
         ph      <= '0;
         acc_i   <= '0;
         acc_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (hold) begin
            st <= CS_IDLE;
         end else begin
            case (st)
               CS_IDLE: if (start) begin
                  st      <= CS_RUN;
                  rd_addr <= '0;
                  ph      <= '0;
                  acc_i   <= '0;
                  acc_q   <= '0;
               end
               default: begin
                  acc_i <= acc_i + ACCW'(p_i);
                  acc_q <= acc_q + ACCW'(p_q);
                  ph    <= ph_nxt;
                  if (rd_addr == LAST) begin
                     st      <= CS_IDLE;
                     done    <= 1'b1;
                     rd_addr <= '0;
                  end else begin
                     rd_addr <= rd_addr + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !hold && rd_addr == LAST) |=> (done && !running));
   p_harm_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !running && !hold) |-> ({1'b0, harm} < (AW+1)'(N)));
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !hold && rd_addr != LAST) |=> (running && rd_addr == $past(rd_addr) + 1'b1));
   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!running && !done));

endmodule

// File: rtl/comb_avg_filter.sv
module comb_avg_filter #(
   parameter int N      = 1000,
   parameter int DW     = 16,
   parameter int GUARD  = 4,
   parameter int SKW    = 3,
   parameter int CNTW   = 8,
   parameter int QBITS  = 8,
   parameter int TW     = 16,
   parameter int ACCW   = 48,
   localparam int AW    = $clog2(N),
   localparam int BW    = DW + GUARD,
   localparam int POSW  = QBITS + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic signed [DW-1:0]   smp_data,
   input  logic [SKW-1:0]         avg_shift,
   input  logic                   clr,
   input  logic                   start,
   input  logic [AW-1:0]          harm,
   output logic                   busy,
   output logic                   done,
   output logic signed [ACCW-1:0] vec_i,
   output logic signed [ACCW-1:0] vec_q,
   output logic [CNTW-1:0]        periods
);
   if (N < 4) begin : g_bad_n
      $error("comb_avg_filter: N must be at least 4");
   end
   if (GUARD < 1 || GUARD > (1 << SKW) - 1) begin : g_bad_guard
      $error("comb_avg_filter: GUARD must be 1..2^SKW-1");
   end
   if (QBITS < 2) begin : g_bad_qbits
      $error("comb_avg_filter: QBITS must be at least 2");
   end
   if (ACCW < BW + TW + AW) begin : g_bad_accw
      $error("comb_avg_filter: ACCW too narrow for N products");
   end

   logic                 clearing;
   logic                 running;
   logic [AW-1:0]        rd_addr;
   logic signed [BW-1:0] rd_word;
   logic [POSW-1:0]      pos;
   logic signed [TW-1:0] sin_v;
   logic signed [TW-1:0] cos_v;

   comb_ring_acc #(
      .N(N), .DW(DW), .GUARD(GUARD), .SKW(SKW), .CNTW(CNTW)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .smp_valid(smp_valid), .smp_data(smp_data), .avg_shift(avg_shift),
      .rd_addr(rd_addr), .rd_word(rd_word),
      .clearing(clearing), .periods(periods)
   );

   comb_trig_lut #(
      .QBITS(QBITS), .TW(TW)
   ) u_lut (
      .pos(pos), .sin_v(sin_v), .cos_v(cos_v)
   );

   comb_correlator #(
      .N(N), .BW(BW), .TW(TW), .QBITS(QBITS), .ACCW(ACCW)
   ) u_corr (
      .clk(clk), .rst_n(rst_n), .start(start), .hold(clr || clearing),
      .harm(harm), .rd_word(rd_word), .sin_v(sin_v), .cos_v(cos_v),
      .rd_addr(rd_addr), .pos(pos), .running(running), .done(done),
      .acc_i(vec_i), .acc_q(vec_q)
   );

   assign busy = clearing || running;

   p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(clearing && running));

endmodule

// File: tb/sim_comb_avg_filter.sv
module sim_comb_avg_filter;
   localparam int N     = 8;
   localparam int DW    = 16;
   localparam int GUARD = 4;
   localparam int SKW   = 3;
   localparam int CNTW  = 3;
   localparam int QBITS = 8;
   localparam int TW    = 16;
   localparam int ACCW  = 48;
   localparam int AW    = $clog2(N);
   localparam longint AMP = 32767;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   smp_valid = 1'b0;
   logic signed [DW-1:0]   smp_data = '0;
   logic [SKW-1:0]         avg_shift = '0;
   logic                   clr = 1'b0;
   logic                   start = 1'b0;
   logic [AW-1:0]          harm = '0;
   logic                   busy;
   logic                   done;
   logic signed [ACCW-1:0] vec_i;
   logic signed [ACCW-1:0] vec_q;
   logic [CNTW-1:0]        periods;

   int total = 0;
   int bad   = 0;
   int mdl [N];
   int mwp  = 0;
   int mper = 0;
   int cur_k = 0;

   always #5 clk = ~clk;

   comb_avg_filter #(
      .N(N), .DW(DW), .GUARD(GUARD), .SKW(SKW), .CNTW(CNTW),
      .QBITS(QBITS), .TW(TW), .ACCW(ACCW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .avg_shift(avg_shift), .clr(clr), .start(start), .harm(harm),
      .busy(busy), .done(done), .vec_i(vec_i), .vec_q(vec_q), .periods(periods)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int upd(input int old, input int s, input int k);
      int ke = (k > GUARD) ? GUARD : k;
      return old + s - (old >>> ke);
   endfunction

   task automatic model_clear();
      for (int i = 0; i < N; i++) mdl[i] = 0;
      mwp  = 0;
      mper = 0;
   endtask

   task automatic model_push(input int s);
      mdl[mwp] = upd(mdl[mwp], s, cur_k);
      mwp = (mwp + 1) % N;
      if (mwp == 0 && mper < 7) mper++;
   endtask

   task automatic push(input int s);
      smp_valid = 1'b1;
      smp_data  = DW'(s);
      @(negedge clk);
      smp_valid = 1'b0;
      model_push(s);
   endtask

   task automatic expect_vec(input int h, output longint ei, output longint eq);
      ei = 0;
      eq = 0;
      for (int i = 0; i < N; i++) begin
         int p = (i * h) % N;
         longint c = (p == 0) ? AMP : (p == 4) ? -AMP : 0;
         longint s = (p == 2) ? AMP : (p == 6) ? -AMP : 0;
         ei += longint'(mdl[i]) * c;
         eq += longint'(mdl[i]) * s;
      end
   endtask

   // Readout; optional forwarded samples and optional second start pulse
   task automatic readout(input int h, input bit fwd, input int restart_at, input string req);
      longint ei, eq;
      int fdat [N];
      bit timing_ok = 1'b1;
      for (int c = 0; c < N; c++) fdat[c] = 37 * c * c - 150 * (c + 1);
      if (fwd) for (int c = 0; c < N; c++) model_push(fdat[c]);
      expect_vec(h, ei, eq);
      harm  = AW'(h);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= N + 3; c++) begin
         if (done !== (c == N + 1)) timing_ok = 1'b0;
         if (c == N + 1) begin
            chk(longint'(vec_i) == ei, req, $sformatf("vec_i h=%0d", h), longint'(vec_i), ei);
            chk(longint'(vec_q) == eq, req, $sformatf("vec_q h=%0d", h), longint'(vec_q), eq);
         end
         smp_valid = fwd && (c <= N);
         smp_data  = (fwd && c <= N) ? DW'(fdat[c-1]) : '0;
         start     = (c == restart_at);
         @(negedge clk);
      end
      smp_valid = 1'b0;
      start     = 1'b0;
      chk(timing_ok, "R4", "done only N cycles after start", longint'(timing_ok), 1);
   endtask

   task automatic do_clear();
      int cnt = 0;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      while (busy && cnt < 4 * N) begin
         cnt++;
         @(negedge clk);
      end
      chk(cnt == N, "R8", "clear length", cnt, N);
      model_clear();
   endtask

   task automatic t_reset();
      int cnt = 0;
      @(negedge clk);
      chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      chk(periods == 0, "R1", "periods in reset", periods, 0);
      rst_n = 1'b1;
      while (busy && cnt < 4 * N) begin
         cnt++;
         @(negedge clk);
      end
      chk(cnt == N, "R1", "reset zeroing length", cnt, N);
      model_clear();
      readout(0, 1'b0, 0, "R1");
   endtask

   task automatic t_pointer();
      cur_k = 0;
      avg_shift = '0;
      for (int i = 0; i < N; i++) push(1000 * (i + 1) - 4321 + 97 * i * i);
      chk(periods == 1, "R2", "one wrap", periods, 1);
      readout(0, 1'b0, 0, "R5");
      readout(2, 1'b0, 0, "R2");
      readout(4, 1'b0, 0, "R5");
      readout(6, 1'b0, 0, "R5");
   endtask

   task automatic t_leaky();
      do_clear();
      cur_k = 2;
      avg_shift = SKW'(2);
      for (int i = 0; i < 3 * N; i++) push((i % N) * 1000 - 3500);
      readout(0, 1'b0, 0, "R3");
      readout(4, 1'b0, 0, "R3");
      cur_k = 7;
      avg_shift = SKW'(7);
      for (int i = 0; i < 4 * N; i++) push((i % 2 == 0) ? 32767 : -32768);
      readout(0, 1'b0, 0, "R3");
      readout(2, 1'b0, 0, "R3");
   endtask

   task automatic t_forward();
      do_clear();
      cur_k = 0;
      avg_shift = '0;
      for (int i = 0; i < N; i++) push(-2000 + 333 * i);
      readout(2, 1'b1, 0, "R6");
      readout(0, 1'b0, 0, "R6");
   endtask

   task automatic t_start_ignored();
      bit seen = 1'b0;
      readout(4, 1'b0, 3, "R7");
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 3 * N; c++) begin
         if (done) seen = 1'b1;
         @(negedge clk);
      end
      chk(!seen, "R7", "no done after start during clear", seen, 0);
      chk(!busy, "R7", "idle after clear", busy, 0);
      model_clear();
   endtask

   task automatic t_clear();
      bit seen = 1'b0;
      int cnt = 0;
      cur_k = 0;
      avg_shift = '0;
      for (int i = 0; i < N + 3; i++) push(5000 - 700 * i);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      smp_valid = 1'b1;
      smp_data  = DW'(12345);
      while (busy && cnt < 4 * N) begin
         cnt++;
         @(negedge clk);
      end
      smp_valid = 1'b0;
      chk(cnt == N, "R8", "clear length with samples", cnt, N);
      chk(periods == 0, "R8", "periods cleared", periods, 0);
      model_clear();
      readout(0, 1'b0, 0, "R8");
      push(100);
      readout(2, 1'b0, 0, "R8");
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      for (int c = 0; c < 2 * N; c++) begin
         if (done) seen = 1'b1;
         @(negedge clk);
      end
      chk(!seen, "R8", "aborted readout gives no done", seen, 0);
      chk(!busy, "R8", "idle after abort clear", busy, 0);
      model_clear();
   endtask

   task automatic t_periods();
      do_clear();
      cur_k = 0;
      avg_shift = '0;
      for (int p = 1; p <= 9; p++) begin
         for (int i = 0; i < N; i++) push(i);
         if (p == 1 || p == 6 || p == 7 || p == 9) begin
            chk(int'(periods) == ((p > 7) ? 7 : p), "R9", $sformatf("periods after %0d", p),
                periods, (p > 7) ? 7 : p);
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_pointer();
      t_leaky();
      t_forward();
      t_start_ignored();
      t_clear();
      t_periods();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule